// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Per-Character Error Tags

This block is the receive half of an asynchronous serial port. It synchronises the incoming line and times it with an external tick that runs at sixteen times the bit rate. It finds a start bit and checks it again at mid-bit, then collects five to eight data bits, least significant first. It can check a parity bit and then checks one stop bit. Every finished character is written into a receive queue together with four error tags. The queue is either a multi-entry FIFO or a single holding register.

A line that is held low for a whole frame is reported as a break. The break writes a zero character and then stops reception until the line returns high. When the queue is full, an arriving character is dropped and the stored contents stay as they are. The next character that is stored carries the overrun tag. A separate sticky status word collects the error tags of the characters that have been read, and it is cleared through a dedicated input.

Top module: `rx_frame_engine`

## Requirements
- R1: After reset, rx_empty is 1, rx_full is 0, rd_data is 0 and stat_flags is 0.
- R2: cfg_wlen selects the data width as 5 + cfg_wlen bits (0 gives 5 and 3 gives 8). Bits arrive least significant first and unused upper data bits read as zero. An entry is packed as {overrun[11], break[10], parity[9], framing[8], data[7:0]}.
- R3: With cfg_par_en set and cfg_par_stick clear, one parity bit follows the data. With cfg_par_even=1 the data bits plus the parity bit must hold an even number of ones; with cfg_par_even=0 the count must be odd. A mismatch sets bit 9 of the entry.
- R4: With cfg_par_stick and cfg_par_en both set, the expected parity bit is the inverse of cfg_par_even. A mismatch sets bit 9.
- R5: A low stop bit sets bit 8. Only one stop bit is checked. After a framing error the receiver waits for the line to go high before it accepts a new start bit.
- R6: If every sample of a frame is low (start, data, parity if enabled, stop), a single entry 0x400 is written. No further entry follows until the line has gone high and a new start bit has arrived.
- R7: With cfg_fifo_en=1 the queue holds DEPTH entries. A character that completes while the queue is full is dropped, and the stored entries are unchanged. stat_flags[3] is set at that moment. The next character that is stored carries bit 11.
- R8: With cfg_fifo_en=0 the queue holds one entry, rx_full rises once that entry is present, and overrun behaves as in R7.
- R9: rd_data always shows the oldest entry. A high rd_en pops that entry. When the queue is empty, rd_data is 0 and rd_en has no effect on the queue or on stat_flags.
- R10: stat_flags = {overrun, break, parity, framing}. A read loads bits 2..0 from the popped entry. Bit 3 is set at an overrun. A pulse on stat_clr clears all four bits.
- R11: If cfg_rx_en drops in the middle of a character, that character still completes and is stored. While cfg_rx_en is low, no new character is started.
- R12: A low pulse that is shorter than half a bit is not treated as a start bit and writes no entry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rxd | input | 1 | Asynchronous serial line, idle high |
| baud_tick | input | 1 | One-cycle pulse at 16x the bit rate |
| cfg_wlen | input | 2 | Data width code, width = 5 + code |
| cfg_par_en | input | 1 | Parity bit present and checked |
| cfg_par_even | input | 1 | Even parity select |
| cfg_par_stick | input | 1 | Fixed parity bit, equal to the inverse of even select |
| cfg_fifo_en | input | 1 | 1 = multi-entry queue, 0 = single holding register |
| cfg_rx_en | input | 1 | Allows new characters to start |
| rd_en | input | 1 | Pop the oldest entry |
| rd_data | output | 12 | Oldest entry {oe, be, pe, fe, data} |
| rx_empty | output | 1 | Queue holds no entry |
| rx_full | output | 1 | Queue is at its capacity |
| stat_clr | input | 1 | Clears stat_flags |
| stat_flags | output | 4 | Sticky {oe, be, pe, fe} |

## Verification
Random frames use every data width and every parity mode, with occasional inverted parity bits and low stop bits. Mismatches in these frames separate masking errors, bit-order errors and parity-polarity errors, and show whether the framing flag is independent of the others. Directed patterns cover the cases that random stimulus rarely reaches:
- a line held low for three frame times, which separates a single break entry from repeated zero characters;
- a short low glitch, which tests start validation;
- nine characters into a full queue and two into the holding register, which show that stored data survives and that the overrun tag is attached to the next character stored;
- a receive-enable drop in the middle of a character.

// File: rtl/rxe_pkg.sv
package rxe_pkg;

    localparam int DATA_W  = 8;
    localparam int ENTRY_W = DATA_W + 4;

    // character as produced by the deframer
    typedef struct packed {
        logic              be;
        logic              pe;
        logic              fe;
        logic [DATA_W-1:0] data;
    } rx_char_t;

    // queue entry, bit 11 down to bit 0: oe, be, pe, fe, data
    typedef struct packed {
        logic              oe;
        logic              be;
        logic              pe;
        logic              fe;
        logic [DATA_W-1:0] data;
    } rx_entry_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PAR,
        ST_STOP,
        ST_MARK
    } rx_state_e;

    function automatic logic [3:0] wlen_bits(input logic [1:0] code);
        return 4'd5 + {2'b00, code};
    endfunction

    function automatic logic expected_parity(input logic [DATA_W-1:0] d,
                                             input logic even,
                                             input logic stick);
        if (stick)
            return ~even;
        return even ? (^d) : ~(^d);
    endfunction

endpackage

// File: rtl/rxe_sync.sv
module rxe_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) chain <= '1;
                else     chain <= din;
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (rst) chain <= '1;
                else     chain <= {chain[STAGES-2:0], din};
            end
        end
    endgenerate

    assign dout = chain[STAGES-1];
endmodule

// File: rtl/rxe_deframer.sv
module rxe_deframer
    import rxe_pkg::*;
#(
    parameter int OVS = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  logic       line,
    input  logic [1:0] wlen,
    input  logic       par_en,
    input  logic       par_even,
    input  logic       par_stick,
    input  logic       rx_en,
    output logic       chr_valid,
    output rx_char_t   chr
);
    localparam int CW = $clog2(OVS);
    localparam logic [CW-1:0] LAST = CW'(OVS - 1);
    localparam logic [CW-1:0] HALF = CW'(OVS / 2 - 1);

    rx_state_e         state;
    logic [CW-1:0]     ovs_cnt;
    logic [2:0]        bit_idx;
    logic [DATA_W-1:0] shreg;
    logic              all_low;
    logic              par_bit;
    logic [3:0]        lat_bits;
    logic              lat_pen;
    logic              lat_even;
    logic              lat_stick;

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            ovs_cnt   <= '0;
            bit_idx   <= '0;
            shreg     <= '0;
            all_low   <= 1'b0;
            par_bit   <= 1'b0;
            lat_bits  <= 4'd8;
            lat_pen   <= 1'b0;
            lat_even  <= 1'b0;
            lat_stick <= 1'b0;
            chr_valid <= 1'b0;
            chr       <= '0;
        end else begin
            chr_valid <= 1'b0;
            if (tick) begin
                case (state)
                    ST_IDLE: begin
                        if (rx_en && !line) begin
                            state   <= ST_START;
                            ovs_cnt <= '0;
                        end
                    end
                    ST_START: begin
                        if (ovs_cnt == HALF) begin
                            ovs_cnt <= '0;
                            if (line) begin
                                state <= ST_IDLE;
                            end else begin
                                state     <= ST_DATA;
                                bit_idx   <= '0;
                                shreg     <= '0;
                                all_low   <= 1'b1;
                                lat_bits  <= wlen_bits(wlen);
                                lat_pen   <= par_en;
                                lat_even  <= par_even;
                                lat_stick <= par_stick;
                            end
                        end else begin
                            ovs_cnt <= ovs_cnt + 1'b1;
                        end
                    end
                    ST_DATA: begin
                        if (ovs_cnt == LAST) begin
                            ovs_cnt        <= '0;
                            shreg[bit_idx] <= line;
                            if (line) all_low <= 1'b0;
                            if ({1'b0, bit_idx} == lat_bits - 4'd1)
                                state <= lat_pen ? ST_PAR : ST_STOP;
                            else
                                bit_idx <= bit_idx + 1'b1;
                        end else begin
                            ovs_cnt <= ovs_cnt + 1'b1;
                        end
                    end
                    ST_PAR: begin
                        if (ovs_cnt == LAST) begin
                            ovs_cnt <= '0;
                            par_bit <= line;
                            if (line) all_low <= 1'b0;
                            state   <= ST_STOP;
                        end else begin
                            ovs_cnt <= ovs_cnt + 1'b1;
                        end
                    end
                    ST_STOP: begin
                        if (ovs_cnt == LAST) begin
                            ovs_cnt   <= '0;
                            chr_valid <= 1'b1;
                            if (!line && all_low) begin
                                chr   <= '{be: 1'b1, pe: 1'b0, fe: 1'b0, data: '0};
                                state <= ST_MARK;
                            end else begin
                                chr.be   <= 1'b0;
                                chr.fe   <= ~line;
                                chr.pe   <= lat_pen &&
                                            (par_bit != expected_parity(shreg, lat_even, lat_stick));
                                chr.data <= shreg;
                                state    <= line ? ST_IDLE : ST_MARK;
                            end
                        end else begin
                            ovs_cnt <= ovs_cnt + 1'b1;
                        end
                    end
                    ST_MARK: begin
                        if (line) state <= ST_IDLE;
                    end
                    default: state <= ST_IDLE;
                endcase
            end
        end
    end

    // R6: a break entry carries a zero character and no framing flag
    a_r6_break_zero: assert property (@(posedge clk) disable iff (rst)
        (chr_valid && chr.be) |-> (chr.data == '0 && !chr.fe && !chr.pe));

    // R5: a low line keeps the receiver waiting for mark
    a_r5_mark_hold: assert property (@(posedge clk) disable iff (rst)
        (state == ST_MARK && tick && !line) |=> (state == ST_MARK));

    // R12: a high line at mid start bit aborts the character
    a_r12_glitch_abort: assert property (@(posedge clk) disable iff (rst)
        (state == ST_START && tick && ovs_cnt == HALF && line) |=> (state == ST_IDLE));

    // R11: no character starts while reception is disabled
    a_r11_idle_gate: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE && !rx_en) |=> (state == ST_IDLE));
endmodule

// File: rtl/rxe_queue.sv
module rxe_queue
    import rxe_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      fifo_en,
    input  logic      push,
    input  rx_char_t  push_chr,
    input  logic      pop,
    output rx_entry_t head,
    output logic      empty,
    output logic      full,
    output logic      ovr
);
    localparam int AW    = $clog2(DEPTH);
    localparam int CNT_W = AW + 1;

    rx_entry_t        mem [DEPTH];
    logic [AW-1:0]    wptr;
    logic [AW-1:0]    rptr;
    logic [CNT_W-1:0] count;
    logic [CNT_W-1:0] cap;
    logic             ovr_pend;
    logic             do_push;
    logic             do_pop;

    assign cap     = fifo_en ? CNT_W'(DEPTH) : CNT_W'(1);
    assign empty   = (count == '0);
    assign full    = (count >= cap);
    assign do_pop  = pop && !empty;
    assign do_push = push && !full;
    assign ovr     = push && full;
    assign head    = empty ? '0 : mem[rptr];

    always_ff @(posedge clk) begin
        if (do_push)
            mem[wptr] <= '{oe: ovr_pend, be: push_chr.be, pe: push_chr.pe,
                           fe: push_chr.fe, data: push_chr.data};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr     <= '0;
            rptr     <= '0;
            count    <= '0;
            ovr_pend <= 1'b0;
        end else begin
            if (do_push) wptr <= wptr + 1'b1;
            if (do_pop)  rptr <= rptr + 1'b1;
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
            if (ovr)          ovr_pend <= 1'b1;
            else if (do_push) ovr_pend <= 1'b0;
        end
    end

    // R7: a character arriving at a full queue leaves its contents alone
    a_r7_full_keeps: assert property (@(posedge clk) disable iff (rst)
        (push && full && !pop) |=> (count == $past(count) && wptr == $past(wptr)));

    // R8: the holding register never grows past one entry
    a_r8_hold_one: assert property (@(posedge clk) disable iff (rst)
        (!fifo_en && !empty && push && !pop) |=> (count == $past(count)));

    // R7: the entry stored after an overrun carries the overrun tag
    a_r7_tag_next: assert property (@(posedge clk) disable iff (rst)
        (ovr_pend && do_push) |=> mem[$past(wptr)].oe);
endmodule

// File: rtl/rx_frame_engine.sv
module rx_frame_engine
    import rxe_pkg::*;
#(
    parameter int DEPTH       = 8,
    parameter int OVS         = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               rxd,
    input  logic               baud_tick,
    input  logic [1:0]         cfg_wlen,
    input  logic               cfg_par_en,
    input  logic               cfg_par_even,
    input  logic               cfg_par_stick,
    input  logic               cfg_fifo_en,
    input  logic               cfg_rx_en,
    input  logic               rd_en,
    output logic [ENTRY_W-1:0] rd_data,
    output logic               rx_empty,
    output logic               rx_full,
    input  logic               stat_clr,
    output logic [3:0]         stat_flags
);
    logic      line_s;
    logic      chr_valid;
    rx_char_t  chr;
    rx_entry_t head;
    logic      ovr;
    logic      rd_pop;

    rxe_sync #(.STAGES(SYNC_STAGES)) i_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (rxd),
        .dout (line_s)
    );

    rxe_deframer #(.OVS(OVS)) i_deframer (
        .clk       (clk),
        .rst       (rst),
        .tick      (baud_tick),
        .line      (line_s),
        .wlen      (cfg_wlen),
        .par_en    (cfg_par_en),
        .par_even  (cfg_par_even),
        .par_stick (cfg_par_stick),
        .rx_en     (cfg_rx_en),
        .chr_valid (chr_valid),
        .chr       (chr)
    );

    rxe_queue #(.DEPTH(DEPTH)) i_queue (
        .clk      (clk),
        .rst      (rst),
        .fifo_en  (cfg_fifo_en),
        .push     (chr_valid),
        .push_chr (chr),
        .pop      (rd_en),
        .head     (head),
        .empty    (rx_empty),
        .full     (rx_full),
        .ovr      (ovr)
    );

    assign rd_data = head;
    assign rd_pop  = rd_en && !rx_empty;

    always_ff @(posedge clk) begin
        if (rst) begin
            stat_flags <= '0;
        end else begin
            if (stat_clr) stat_flags <= '0;
            if (rd_pop)   stat_flags[2:0] <= {head.be, head.pe, head.fe};
            if (ovr)      stat_flags[3] <= 1'b1;
        end
    end

    // R9: an empty queue presents a zero entry
    a_r9_empty_zero: assert property (@(posedge clk) disable iff (rst)
        rx_empty |-> (rd_data == '0));

    // R10: a clear with no competing event leaves all flags low
    a_r10_clear: assert property (@(posedge clk) disable iff (rst)
        (stat_clr && !rd_pop && !ovr) |=> (stat_flags == 4'b0000));

    // R10: the overrun flag holds until cleared
    a_r10_oe_sticky: assert property (@(posedge clk) disable iff (rst)
        (stat_flags[3] && !stat_clr) |=> stat_flags[3]);
endmodule

// File: tb/test_rx_frame_engine.sv
module test_rx_frame_engine;

    localparam int BIT_CLK = 64;          // 16 ticks of 4 clocks each
    localparam int WD_CYC  = 190000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        rxd = 1'b1;
    logic        baud_tick = 1'b0;
    logic [1:0]  cfg_wlen = 2'd3;
    logic        cfg_par_en = 1'b0;
    logic        cfg_par_even = 1'b0;
    logic        cfg_par_stick = 1'b0;
    logic        cfg_fifo_en = 1'b1;
    logic        cfg_rx_en = 1'b1;
    logic        rd_en = 1'b0;
    logic        stat_clr = 1'b0;
    logic [11:0] rd_data;
    logic        rx_empty;
    logic        rx_full;
    logic [3:0]  stat_flags;

    int n_chk  = 0;
    int n_fail = 0;

    rx_frame_engine i_rx_frame_engine (
        .clk           (clk),
        .rst           (rst),
        .rxd           (rxd),
        .baud_tick     (baud_tick),
        .cfg_wlen      (cfg_wlen),
        .cfg_par_en    (cfg_par_en),
        .cfg_par_even  (cfg_par_even),
        .cfg_par_stick (cfg_par_stick),
        .cfg_fifo_en   (cfg_fifo_en),
        .cfg_rx_en     (cfg_rx_en),
        .rd_en         (rd_en),
        .rd_data       (rd_data),
        .rx_empty      (rx_empty),
        .rx_full       (rx_full),
        .stat_clr      (stat_clr),
        .stat_flags    (stat_flags)
    );

    always #4 clk = ~clk;

    initial begin
        forever begin
            repeat (3) @(negedge clk);
            baud_tick = 1'b1;
            @(negedge clk);
            baud_tick = 1'b0;
        end
    end

    task automatic chk(input string tag, input logic [11:0] act, input logic [11:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic put(input logic v, input int nbits);
        rxd = v;
        repeat (nbits * BIT_CLK) @(negedge clk);
    endtask

    function automatic logic [7:0] mask_of(input logic [7:0] d, input logic [1:0] wl);
        return d & (8'hFF >> (2'd3 - wl));
    endfunction

    function automatic logic par_of(input logic [7:0] m, input logic even, input logic stick);
        if (stick) return ~even;
        return even ? (^m) : ~(^m);
    endfunction

    // expected entry {oe, be, pe, fe, data}
    function automatic logic [11:0] model(input logic [7:0] d, input logic [1:0] wl,
                                          input logic pen, input logic even, input logic stick,
                                          input logic bad_par, input logic bad_stop);
        logic [7:0] m;
        logic       sp;
        m  = mask_of(d, wl);
        sp = par_of(m, even, stick) ^ bad_par;
        if (bad_stop && m == 8'h00 && (!pen || !sp))
            return 12'h400;
        return {1'b0, 1'b0, pen && bad_par, bad_stop, m};
    endfunction

    task automatic send(input logic [7:0] d, input logic bad_par, input logic bad_stop);
        logic [7:0] m;
        m = mask_of(d, cfg_wlen);
        put(1'b0, 1);
        for (int i = 0; i < 5 + int'(cfg_wlen); i++) put(m[i], 1);
        if (cfg_par_en) put(par_of(m, cfg_par_even, cfg_par_stick) ^ bad_par, 1);
        put(~bad_stop, 1);
        put(1'b1, 2);
    endtask

    task automatic read_chk(input string tag, input logic [11:0] exp);
        @(negedge clk);
        chk(tag, rd_data, exp);
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic clear_stat();
        stat_clr = 1'b1;
        @(negedge clk);
        stat_clr = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        #(WD_CYC * 8);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_0017));
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: reset state
        chk("R1 empty", {11'd0, rx_empty}, 12'd1);
        chk("R1 full", {11'd0, rx_full}, 12'd0);
        chk("R1 data", rd_data, 12'h000);
        chk("R1 stat", {8'd0, stat_flags}, 12'd0);
        put(1'b1, 2);

        // R2: 5-bit characters are zero-filled above bit 4
        cfg_wlen = 2'd0;
        send(8'hFF, 1'b0, 1'b0);
        read_chk("R2 wlen5", 12'h01F);
        cfg_wlen = 2'd3;
        send(8'hA5, 1'b0, 1'b0);
        read_chk("R2 wlen8", 12'h0A5);

        // R3: even and odd parity with a wrong parity bit
        cfg_par_en = 1'b1; cfg_par_even = 1'b1;
        send(8'h37, 1'b1, 1'b0);
        read_chk("R3 even bad", 12'h237);
        cfg_par_even = 1'b0;
        send(8'h37, 1'b0, 1'b0);
        read_chk("R3 odd good", 12'h037);

        // R4: stick parity, expected bit = ~even
        cfg_par_stick = 1'b1; cfg_par_even = 1'b0;
        send(8'h01, 1'b1, 1'b0);
        read_chk("R4 stick bad", 12'h201);
        cfg_par_stick = 1'b0; cfg_par_en = 1'b0;

        // R5: low stop bit gives framing error; status follows the read
        clear_stat();
        send(8'h5C, 1'b0, 1'b1);
        read_chk("R5 framing", 12'h15C);
        chk("R10 fe loaded", {8'd0, stat_flags}, 12'h001);

        // R6: long low line gives one break entry, then normal reception
        clear_stat();
        put(1'b0, 30);
        put(1'b1, 2);
        read_chk("R6 break entry", 12'h400);
        @(negedge clk);
        chk("R6 single entry", {11'd0, rx_empty}, 12'd1);
        chk("R10 be loaded", {8'd0, stat_flags}, 12'h004);
        send(8'h5A, 1'b0, 1'b0);
        read_chk("R6 resume", 12'h05A);

        // R9: read on empty changes neither queue nor status
        clear_stat();
        send(8'h00, 1'b0, 1'b1);           // 8-bit zero with low stop: break
        read_chk("R6 zero frame", 12'h400);
        read_chk("R9 empty read data", 12'h000);
        chk("R9 stat kept", {8'd0, stat_flags}, 12'h004);
        chk("R9 still empty", {11'd0, rx_empty}, 12'd1);

        // R10: clear
        clear_stat();
        chk("R10 cleared", {8'd0, stat_flags}, 12'h000);

        // R12: a short low glitch is ignored
        put(1'b0, 0);
        repeat (16) @(negedge clk);
        put(1'b1, 2);
        chk("R12 glitch", {11'd0, rx_empty}, 12'd1);

        // R7: overrun in queue mode
        for (int i = 1; i <= 9; i++) send(8'(i), 1'b0, 1'b0);
        chk("R7 full", {11'd0, rx_full}, 12'd1);
        chk("R7 sticky oe", {8'd0, stat_flags}, 12'h008);
        for (int i = 1; i <= 8; i++) read_chk("R7 kept", 12'(i));
        send(8'h33, 1'b0, 1'b0);
        read_chk("R7 tagged next", 12'h833);
        send(8'h44, 1'b0, 1'b0);
        read_chk("R7 tag once", 12'h044);

        // R8: single holding register
        clear_stat();
        cfg_fifo_en = 1'b0;
        send(8'hC1, 1'b0, 1'b0);
        chk("R8 full one", {11'd0, rx_full}, 12'd1);
        send(8'hC2, 1'b0, 1'b0);
        chk("R8 oe", {8'd0, stat_flags}, 12'h008);
        read_chk("R8 first kept", 12'h0C1);
        send(8'hC3, 1'b0, 1'b0);
        read_chk("R8 tagged", 12'h8C3);
        cfg_fifo_en = 1'b1;

        // R11: receive enable dropped mid-character
        fork
            send(8'h6E, 1'b0, 1'b0);
            begin
                repeat (3 * BIT_CLK) @(negedge clk);
                cfg_rx_en = 1'b0;
            end
        join
        read_chk("R11 finished", 12'h06E);
        send(8'h11, 1'b0, 1'b0);
        chk("R11 no start", {11'd0, rx_empty}, 12'd1);
        cfg_rx_en = 1'b1;
        put(1'b1, 1);

        // random frames across all formats
        clear_stat();
        for (int n = 0; n < 40; n++) begin
            logic [7:0]  d;
            logic        bp;
            logic        bs;
            logic [11:0] e;
            string       tag;
            cfg_wlen      = 2'($urandom);
            cfg_par_en    = 1'($urandom);
            cfg_par_even  = 1'($urandom);
            cfg_par_stick = 1'($urandom);
            d  = 8'($urandom);
            bp = ($urandom % 5) == 0;
            bs = ($urandom % 6) == 0;
            e  = model(d, cfg_wlen, cfg_par_en, cfg_par_even, cfg_par_stick, bp, bs);
            tag = bs ? "R5 rand" : (bp && cfg_par_en) ? (cfg_par_stick ? "R4 rand" : "R3 rand") : "R2 rand";
            send(d, bp, bs);
            read_chk(tag, e);
            chk("R10 rand stat", {8'd0, stat_flags}, {9'd0, e[10:8]});
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule